// File: doc/BRIEF.md
# Timer Compare Channel Bank

This block holds a bank of compare channels that watch one free-running 16-bit timer count supplied from outside. Each channel keeps a compare value written by software. On every clock it tests that value for equality with the timer. When they are equal, the channel changes its output pin and latches an interrupt flag. The timer, its overflow detection and interrupt prioritisation all live outside the block.

Each channel runs in one of two modes, chosen by a control bit.

- **Mode 0 (set/clear).** The channel drives its pin high on a match and low on the timer overflow strobe. The comparator does not see the software register directly. It reads a shadow copy that is refreshed only when the timer overflows, so rewriting the value in the middle of a period cannot lose the current period's match.
- **Mode 1 (programmed level).** The channel compares against the software register directly. On a match it copies a software-held level bit to the pin, and overflow does not touch the pin.

Software reaches both the compare values and the control bits through one write port. The address carries a channel number plus a flag that picks between the value and the control word. Interrupt flags are cleared by a separate write-one-to-clear vector.

Top module: `cmp_bank`

## Requirements
- R1: A channel matches when `tmr_cnt` equals its active compare value across all 16 bits. The pin changes only at the clock edge where a match or, in mode 0, an overflow is seen.
- R2: A match sets the channel's `irq_flag`. The flag stays set until a 1 on that channel's `irq_clr` bit clears it. A match in the same cycle as the clear leaves the flag set.
- R3: In mode 0 the pin goes high on a match and goes low on a cycle where `tmr_ovf` is 1.
- R4: In mode 0, when a match and an overflow fall on the same cycle, the pin ends low. The interrupt flag is still set.
- R5: In mode 0 the comparator uses a shadow copy of the compare value. The shadow copy loads the software value on every `tmr_ovf` cycle. A value written in the same cycle as an overflow reaches the shadow only at the following overflow.
- R6: In mode 1 the comparator uses the software value as soon as it is written. On a match the pin takes the channel's level bit. The level bit can be rewritten at any time and acts only at the next match.
- R7: In mode 1 a `tmr_ovf` cycle without a match leaves the pin unchanged.
- R8: While `rst` is high, and after it falls, every pin and flag is 0. Every compare value and shadow copy is 0xFFFF, and every channel is in mode 0 with level 0.
- R9: A write with `wr_addr[3]`=0 stores `wr_data` as the compare value of channel `wr_addr[2:0]`. A write with `wr_addr[3]`=1 stores the control word of that channel: `wr_data[0]` is the mode and `wr_data[1]` is the level. Other channels are not affected.
- R10: `cmp_out` and `irq_flag` come straight from registers. They change one clock edge after the inputs that cause the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | 16 | Current timer count |
| tmr_ovf | input | 1 | Overflow strobe, high for one cycle when the timer wraps |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Bit 3 selects control (1) or compare value (0); bits 2:0 select the channel |
| wr_data | input | 16 | Write data |
| irq_clr | input | 8 | Write-one-to-clear, one bit per channel |
| cmp_out | output | 8 | Compare output pins |
| irq_flag | output | 8 | Interrupt request flags |

## Verification
The bound checker watches several rules on every cycle:
- a mode-0 overflow always leaves the pin low, and a mode-1 overflow without a match leaves it unchanged;
- a rising pin is always preceded by a match;
- interrupt flags set on a match, hold until cleared, and drop on a clear without a match;
- reset leaves pins and flags at zero.

Other behaviour depends on stored values and can only be shown by the bench's scenarios. This covers the shadow copy ignoring a mid-period write until the next overflow, the exact level driven in mode 1, the 0xFFFF reset values, and the address decode reaching the right channel.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef enum logic [0:0] {
    CM_SET_CLR = 1'b0,
    CM_LEVEL   = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    cmp_mode_e mode;
    logic      level;
  } chan_ctl_t;

  localparam chan_ctl_t CTL_RESET = '{mode: CM_SET_CLR, level: 1'b0};

endpackage

// File: rtl/cmp_store.sv
module cmp_store
  import cmp_pkg::*;
#(
  parameter int            TW   = 16,
  parameter logic [TW-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_val,
  input  logic          wr_ctl,
  input  logic [TW-1:0] wr_data,
  input  logic          tmr_ovf,
  output logic [TW-1:0] ref_q,
  output logic [TW-1:0] shadow_q,
  output chan_ctl_t     ctl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q    <= INIT;
      shadow_q <= INIT;
      ctl_q    <= CTL_RESET;
    end else begin
      if (wr_val) ref_q <= wr_data;
      // shadow takes the value held before this edge
      if (tmr_ovf) shadow_q <= ref_q;
      if (wr_ctl) begin
        ctl_q.mode  <= cmp_mode_e'(wr_data[0]);
        ctl_q.level <= wr_data[1];
      end
    end
  end

endmodule

// File: rtl/cmp_pin.sv
module cmp_pin
  import cmp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tmr_cnt,
  input  logic          tmr_ovf,
  input  chan_ctl_t     ctl,
  input  logic [TW-1:0] ref_val,
  input  logic [TW-1:0] shadow_val,
  input  logic          irq_clr,
  output logic          match,
  output logic          pin_q,
  output logic          irq_q
);

  logic [TW-1:0] active;

  assign active = (ctl.mode == CM_LEVEL) ? ref_val : shadow_val;
  assign match  = (tmr_cnt == active);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= match | (irq_q & ~irq_clr);
      unique case (ctl.mode)
        CM_SET_CLR: begin
          if (tmr_ovf)    pin_q <= 1'b0;
          else if (match) pin_q <= 1'b1;
        end
        CM_LEVEL: begin
          if (match) pin_q <= ctl.level;
        end
      endcase
    end
  end

endmodule

// File: rtl/cmp_bank.sv
module cmp_bank
  import cmp_pkg::*;
#(
  parameter int  N_CH = 8,
  parameter int  TW   = 16,
  localparam int CW   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int AW   = CW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   tmr_cnt,
  input  logic            tmr_ovf,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [TW-1:0]   wr_data,
  input  logic [N_CH-1:0] irq_clr,
  output logic [N_CH-1:0] cmp_out,
  output logic [N_CH-1:0] irq_flag
);

  logic [N_CH-1:0] match_v;
  logic [N_CH-1:0] mode_v;
  logic            ctl_sel;

  assign ctl_sel = wr_addr[AW-1];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic          hit;
    logic [TW-1:0] ref_q;
    logic [TW-1:0] shadow_q;
    chan_ctl_t     ctl_q;

    assign hit       = wr_en && (wr_addr[CW-1:0] == CW'(g));
    assign mode_v[g] = (ctl_q.mode == CM_LEVEL);

    cmp_store #(.TW(TW)) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_val   (hit && !ctl_sel),
      .wr_ctl   (hit && ctl_sel),
      .wr_data  (wr_data),
      .tmr_ovf  (tmr_ovf),
      .ref_q    (ref_q),
      .shadow_q (shadow_q),
      .ctl_q    (ctl_q)
    );

    cmp_pin #(.TW(TW)) u_pin (
      .clk        (clk),
      .rst        (rst),
      .tmr_cnt    (tmr_cnt),
      .tmr_ovf    (tmr_ovf),
      .ctl        (ctl_q),
      .ref_val    (ref_q),
      .shadow_val (shadow_q),
      .irq_clr    (irq_clr[g]),
      .match      (match_v[g]),
      .pin_q      (cmp_out[g]),
      .irq_q      (irq_flag[g])
    );
  end

endmodule

// File: rtl/cmp_bank_chk.sv
module cmp_bank_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            tmr_ovf,
  input logic [N_CH-1:0] irq_clr,
  input logic [N_CH-1:0] mode_v,
  input logic [N_CH-1:0] match_v,
  input logic [N_CH-1:0] cmp_out,
  input logic [N_CH-1:0] irq_flag
);

  AST_RESET_CLEARS: assert property (@(posedge clk) $past(rst) |-> (cmp_out == '0 && irq_flag == '0)); // R8

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    AST_OVF_LOWERS: assert property (@(posedge clk) disable iff (rst) (tmr_ovf && !mode_v[i]) |=> !cmp_out[i]); // R4
    AST_LEVEL_IGNORES_OVF: assert property (@(posedge clk) disable iff (rst) (tmr_ovf && mode_v[i] && !match_v[i]) |=> $stable(cmp_out[i])); // R7
    AST_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst) $rose(cmp_out[i]) |-> $past(match_v[i])); // R1
    AST_MATCH_FLAGS: assert property (@(posedge clk) disable iff (rst) match_v[i] |=> irq_flag[i]); // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst) (irq_flag[i] && !irq_clr[i]) |=> irq_flag[i]); // R2
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst) (irq_clr[i] && !match_v[i]) |=> !irq_flag[i]); // R2
  end

endmodule

bind cmp_bank cmp_bank_chk #(.N_CH(N_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tmr_ovf  (tmr_ovf),
  .irq_clr  (irq_clr),
  .mode_v   (mode_v),
  .match_v  (match_v),
  .cmp_out  (cmp_out),
  .irq_flag (irq_flag)
);

// File: tb/sim_cmp_bank.sv
module sim_cmp_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  // {wr_en, wr_addr, wr_data, tmr_cnt, tmr_ovf, irq_clr, exp_out, exp_irq}
  localparam logic [61:0] VEC [NV] = '{
    {1'b1, 4'h0, 16'h0010, 16'h0005, 1'b0, 8'h00, 8'h00, 8'h00}, // R9 ch0 value
    {1'b0, 4'h0, 16'h0000, 16'h0010, 1'b0, 8'h00, 8'h00, 8'h00}, // R5 shadow still FFFF
    {1'b0, 4'h0, 16'h0000, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00}, // R5 reload
    {1'b0, 4'h0, 16'h0000, 16'h0010, 1'b0, 8'h00, 8'h01, 8'h01}, // R3 set on match
    {1'b0, 4'h0, 16'h0000, 16'h0011, 1'b0, 8'h00, 8'h01, 8'h01}, // R2 flag holds
    {1'b0, 4'h0, 16'h0000, 16'h0012, 1'b0, 8'h01, 8'h01, 8'h00}, // R2 clear
    {1'b0, 4'h0, 16'h0000, 16'h0000, 1'b1, 8'h00, 8'h00, 8'h00}, // R3 overflow lowers
    {1'b1, 4'h9, 16'h0003, 16'h0001, 1'b0, 8'h00, 8'h00, 8'h00}, // R9 ch1 mode1 level1
    {1'b1, 4'h1, 16'h0020, 16'h0002, 1'b0, 8'h00, 8'h00, 8'h00}, // R6 ch1 value
    {1'b0, 4'h0, 16'h0000, 16'h0020, 1'b0, 8'h00, 8'h02, 8'h02}, // R6 direct compare
    {1'b0, 4'h0, 16'h0000, 16'h0000, 1'b1, 8'h00, 8'h02, 8'h02}, // R7 overflow ignored
    {1'b1, 4'h9, 16'h0001, 16'h0021, 1'b0, 8'h00, 8'h02, 8'h02}, // R6 level rewritten
    {1'b0, 4'h0, 16'h0000, 16'h0020, 1'b0, 8'h02, 8'h00, 8'h02}, // R2 match beats clear
    {1'b0, 4'h0, 16'h0000, 16'h0010, 1'b1, 8'h00, 8'h00, 8'h03}, // R4 match+ovf
    {1'b0, 4'h0, 16'h0000, 16'h0003, 1'b0, 8'hFF, 8'h00, 8'h00}, // R2 clear all
    {1'b1, 4'h0, 16'h0030, 16'h0005, 1'b0, 8'h00, 8'h00, 8'h00}, // R5 mid-period write
    {1'b0, 4'h0, 16'h0000, 16'h0010, 1'b0, 8'h00, 8'h01, 8'h01}  // R5 old shadow used
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tmr_cnt = '0;
  logic        tmr_ovf = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  irq_clr = '0;
  logic [7:0]  cmp_out;
  logic [7:0]  irq_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmp_bank u0 (
    .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .tmr_ovf(tmr_ovf),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_clr(irq_clr), .cmp_out(cmp_out), .irq_flag(irq_flag)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [3:0] a, input logic [15:0] d,
                       input logic [15:0] c, input logic o, input logic [7:0] clr);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    tmr_cnt = c; tmr_ovf = o; irq_clr = clr;
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [15:0] d,
                      input logic [15:0] c, input logic o, input logic [7:0] clr);
    drive(we, a, d, c, o, clr);
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 pins in reset", cmp_out, 8'h00);
    chk("R8 flags in reset", irq_flag, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [61:0] v;
      v = VEC[k];
      step(v[61], v[60:57], v[56:41], v[40:25], v[24], v[23:16]);
      chk($sformatf("R1 pins row %0d", k), cmp_out, v[15:8]);
      chk($sformatf("R2 flags row %0d", k), irq_flag, v[7:0]);
    end

    // fresh reset: all values 0xFFFF, all mode 0
    drive(1'b0, 4'h0, 16'h0000, 16'h0000, 1'b0, 8'h00);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 4'h0, 16'h0000, 16'hFFFF, 1'b0, 8'h00);
    chk("R8 reset values 0xFFFF pins", cmp_out, 8'hFF);
    chk("R8 reset values 0xFFFF flags", irq_flag, 8'hFF);
    step(1'b0, 4'h0, 16'h0000, 16'h0000, 1'b1, 8'h00);
    chk("R8 reset mode 0 lowers on ovf", cmp_out, 8'h00);

    // R9 channel 7 addressing, R10 latency
    step(1'b1, 4'h7, 16'h1234, 16'h0001, 1'b0, 8'hFF);
    chk("R2 clear all after reset test", irq_flag, 8'h00);
    step(1'b0, 4'h0, 16'h0000, 16'h0000, 1'b1, 8'h00);
    chk("R5 no match before reload", cmp_out, 8'h00);
    drive(1'b0, 4'h0, 16'h0000, 16'h1234, 1'b0, 8'h00);
    #1;
    chk("R10 no change before edge", cmp_out, 8'h00);
    @(posedge clk);
    #1;
    chk("R9 channel 7 pin", cmp_out, 8'h80);
    chk("R9 channel 7 flag", irq_flag, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule